// File: doc/BRIEF.md
# Membrane Grid Time-Step Engine

This block advances a square grid of membrane nodes by one time step of a second-order two-dimensional wave scheme. Each node's next value is built from a five-point spatial stencil taken at the current step, the node's own current and previous values, and one external stimulus value. Four coefficients are stored per node, so the medium need not be uniform. All arithmetic is signed Q16.16 fixed point.

A host first fills the coefficient store through a small write port. It then pulses `step_go` once per time step. The engine requests one stimulus word per node, in row-major order, and handles one node per cycle once its two-stage pipeline has filled. Each new value is written over the node's oldest value after that old value has been read. Every newly computed boundary-node value is exported on the edge port, where a neighbouring engine could pick it up. When all nodes are written, the engine swaps the roles of its two value banks and pulses `step_done`. In the same cycle it presents the new values of the first node and the last node as its response.

Top module: `membrane_step_engine`

## Requirements
- R1: After reset, both value banks and all coefficients are zero and `busy`, `step_done`, `resp_valid`, `stim_rdy` and `edge_valid` are low. A step taken with all coefficients still zero therefore yields zero responses and zero edge values.
- R2: The stencil for the node at row i, column j (index i*8+j) is up + down + left + right − 4·centre, all from the current bank. A neighbour outside the grid counts as zero. Sums wrap in 32 bits.
- R3: The new value is mul(s1,stencil) + mul(p1,u_now) + mul(p2,u_old) + mul(p3,stim). Here mul(a,b) takes bits 47..16 of the 64-bit signed product, and the sum wraps in 32 bits.
- R4: A coefficient write with `coef_we` high stores `coef_data` for node `coef_addr` (= row*8+col). The field is chosen by `coef_sel`: 0 = s1, 1 = p1, 2 = p2, 3 = p3. It applies to every later step.
- R5: In the cycle after `step_go` is accepted, `stim_rdy` rises. It stays high for exactly 64 consecutive cycles while `stim_idx` counts 0 to 63. `stim_data` is sampled at each of those rising edges for node `stim_idx`.
- R6: Consecutive steps form a three-level recurrence. After a step, the new values become the current values, and the values that were current become the old values.
- R7: `step_done` and `resp_valid` are high for exactly one cycle, 65 rising edges after the edge that accepts `step_go`. In that cycle `resp_first` carries the new value of node 0 and `resp_last` the new value of node 63.
- R8: For every node in row 0, row 7, column 0 or column 7, `edge_valid` pulses with `edge_idx` and `edge_data` set to its new value. The pulse comes two edges after that node's stimulus edge, in row-major order, 28 pulses per step.
- R9: A `step_go` pulse while `busy` is high is ignored. The running step completes normally and no second step follows.
- R10: Coefficient writes while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_go | input | 1 | Start one time step (accepted when idle) |
| busy | output | 1 | Step in progress |
| step_done | output | 1 | One-cycle pulse when all nodes are written |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 2 | Coefficient field: 0 s1, 1 p1, 2 p2, 3 p3 |
| coef_addr | input | 6 | Node index row*8+col |
| coef_data | input | 32 | Q16.16 coefficient value |
| stim_rdy | output | 1 | Engine takes a stimulus word this cycle |
| stim_idx | output | 6 | Node index of the requested stimulus |
| stim_data | input | 32 | Q16.16 stimulus value |
| resp_valid | output | 1 | Response words valid |
| resp_first | output | 32 | New value of node 0 |
| resp_last | output | 32 | New value of node 63 |
| edge_valid | output | 1 | Boundary export valid |
| edge_idx | output | 6 | Index of exported boundary node |
| edge_data | output | 32 | New value of exported boundary node |

## Verification
If the edge that accepts `step_go` is counted as edge 0, the stimulus for node k is taken at edge k+1. That node's boundary export appears after edge k+2, and the done pulse and both response words appear after edge 65. The bench samples every output at the falling edge that follows. At each falling edge it numbers the cycle since start. It checks that stimulus requests appear at cycles 0 to 63, that the index equals the cycle number, and that the done pulse lands at cycle 65 and no other. A software model of the grid, written with 64-bit products, supplies the expected values, including the interference of a start or coefficient write that arrives during a running step.

// File: rtl/memb_pkg.sv
package memb_pkg;

  typedef logic signed [31:0] q16_t;

  typedef struct packed {
    q16_t s1;
    q16_t p1;
    q16_t p2;
    q16_t p3;
  } coef_t;

  typedef struct packed {
    q16_t c;
    q16_t n;
    q16_t s;
    q16_t w;
    q16_t e;
  } nbhd_t;

  // Q16.16 product: bits 47..16 of the full signed product
  function automatic q16_t q_mul(input q16_t a, input q16_t b);
    logic signed [63:0] prod;
    prod = 64'(a) * 64'(b);
    return prod[47:16];
  endfunction

  function automatic q16_t stencil5(input nbhd_t v);
    return v.n + v.s + v.w + v.e - (v.c <<< 2);
  endfunction

  function automatic q16_t node_next(input coef_t k, input q16_t xi,
                                     input q16_t u_now, input q16_t u_old,
                                     input q16_t stim);
    return q_mul(k.s1, xi) + q_mul(k.p1, u_now) + q_mul(k.p2, u_old) + q_mul(k.p3, stim);
  endfunction

  function automatic logic on_rim(input int idx, input int grid);
    int r, c;
    r = idx / grid;
    c = idx % grid;
    return (r == 0) || (r == grid - 1) || (c == 0) || (c == grid - 1);
  endfunction

endpackage

// File: rtl/memb_coef_store.sv
module memb_coef_store
  import memb_pkg::*;
#(
  parameter int NODES = 64,
  localparam int IW = $clog2(NODES),
  localparam int NFIELD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [IW-1:0] addr,
  input  q16_t          data,
  input  logic [IW-1:0] rd_idx,
  output coef_t         rd
);

  logic [NFIELD-1:0][31:0] fld;

  for (genvar fi = 0; fi < NFIELD; fi++) begin : g_fld
    q16_t mem [NODES];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NODES; k++) mem[k] <= '0;
      end else if (we && (sel == 2'(fi))) begin
        mem[addr] <= data;
      end
    end
    assign fld[fi] = mem[rd_idx];
  end

  assign rd.s1 = fld[0];
  assign rd.p1 = fld[1];
  assign rd.p2 = fld[2];
  assign rd.p3 = fld[3];

endmodule

// File: rtl/memb_value_banks.sv
module memb_value_banks
  import memb_pkg::*;
#(
  parameter int GRID = 8,
  localparam int NODES = GRID * GRID,
  localparam int IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsel,      // bank holding u(n)
  input  logic [IW-1:0] rd_idx,
  output nbhd_t         nb,        // stencil inputs from u(n)
  output q16_t          u_old,     // u(n-1) of rd_idx
  input  logic          we,        // writes go to bank !rsel
  input  logic [IW-1:0] widx,
  input  q16_t          wdata,
  output q16_t          wb_first   // node 0 of the bank being written
);

  localparam logic [IW-1:0] ROWSTEP = IW'(GRID);

  int rd_row, rd_col;
  assign rd_row = int'(rd_idx) / GRID;
  assign rd_col = int'(rd_idx) % GRID;

  nbhd_t [1:0] bank_nb;
  logic  [1:0][31:0] bank_first;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    q16_t mem [NODES];
    nbhd_t rdv;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < NODES; k++) mem[k] <= '0;
      end else if (we && (rsel != 1'(b))) begin
        mem[widx] <= wdata;
      end
    end

    always_comb begin
      rdv.c = mem[rd_idx];
      rdv.n = (rd_row != 0)        ? mem[rd_idx - ROWSTEP] : '0;
      rdv.s = (rd_row != GRID - 1) ? mem[rd_idx + ROWSTEP] : '0;
      rdv.w = (rd_col != 0)        ? mem[rd_idx - 1'b1]    : '0;
      rdv.e = (rd_col != GRID - 1) ? mem[rd_idx + 1'b1]    : '0;
    end

    assign bank_nb[b]    = rdv;
    assign bank_first[b] = mem[0];
  end

  assign nb       = bank_nb[rsel];
  assign u_old    = bank_nb[!rsel].c;
  assign wb_first = bank_first[!rsel];

endmodule

// File: rtl/memb_node_pipe.sv
module memb_node_pipe
  import memb_pkg::*;
#(
  parameter int NODES = 64,
  localparam int IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_v,
  input  logic [IW-1:0] iss_idx,
  input  nbhd_t         nb,
  input  q16_t          u_old,
  input  q16_t          stim,
  input  coef_t         coef,
  output logic          wr_v,
  output logic [IW-1:0] wr_idx,
  output q16_t          wr_data
);

  q16_t  xi_r, now_r, old_r, stim_r;
  coef_t coef_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_v   <= 1'b0;
      wr_idx <= '0;
      xi_r   <= '0;
      now_r  <= '0;
      old_r  <= '0;
      stim_r <= '0;
      coef_r <= '0;
    end else begin
      wr_v <= iss_v;
      if (iss_v) begin
        wr_idx <= iss_idx;
        xi_r   <= stencil5(nb);
        now_r  <= nb.c;
        old_r  <= u_old;
        stim_r <= stim;
        coef_r <= coef;
      end
    end
  end

  assign wr_data = node_next(coef_r, xi_r, now_r, old_r, stim_r);

endmodule

// File: rtl/memb_step_seq.sv
module memb_step_seq #(
  parameter int NODES = 64,
  localparam int IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          last_wr,
  output logic          iss_v,
  output logic [IW-1:0] iss_idx,
  output logic          busy,
  output logic          done,
  output logic          rsel
);

  localparam logic [IW-1:0] LAST = IW'(NODES - 1);

  logic go_ok;
  assign go_ok = go && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_v   <= 1'b0;
      iss_idx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rsel    <= 1'b0;
    end else begin
      done <= last_wr;
      if (go_ok) begin
        busy    <= 1'b1;
        iss_v   <= 1'b1;
        iss_idx <= '0;
      end else if (iss_v) begin
        if (iss_idx == LAST) iss_v <= 1'b0;
        else iss_idx <= iss_idx + 1'b1;
      end
      if (last_wr) begin
        busy <= 1'b0;
        rsel <= ~rsel;
      end
    end
  end

endmodule

// File: rtl/membrane_step_engine.sv
module membrane_step_engine
  import memb_pkg::*;
#(
  parameter int GRID = 8,
  localparam int NODES = GRID * GRID,
  localparam int IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_go,
  output logic          busy,
  output logic          step_done,
  input  logic          coef_we,
  input  logic [1:0]    coef_sel,
  input  logic [IW-1:0] coef_addr,
  input  logic [31:0]   coef_data,
  output logic          stim_rdy,
  output logic [IW-1:0] stim_idx,
  input  logic [31:0]   stim_data,
  output logic          resp_valid,
  output logic [31:0]   resp_first,
  output logic [31:0]   resp_last,
  output logic          edge_valid,
  output logic [IW-1:0] edge_idx,
  output logic [31:0]   edge_data
);

  localparam logic [IW-1:0] LAST = IW'(NODES - 1);

  // named internal events used by the checker
  logic          iss_v, wr_v, last_wr, rsel;
  logic [IW-1:0] iss_idx, wr_idx;
  q16_t          wr_data, u_old, wb_first;
  nbhd_t         nb;
  coef_t         coef;

  assign last_wr  = wr_v && (wr_idx == LAST);
  assign stim_rdy = iss_v;
  assign stim_idx = iss_idx;

  memb_step_seq #(.NODES(NODES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(step_go), .last_wr(last_wr),
    .iss_v(iss_v), .iss_idx(iss_idx), .busy(busy), .done(step_done), .rsel(rsel)
  );

  memb_coef_store #(.NODES(NODES)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we && !busy), .sel(coef_sel),
    .addr(coef_addr), .data(coef_data), .rd_idx(iss_idx), .rd(coef)
  );

  memb_value_banks #(.GRID(GRID)) u_banks (
    .clk(clk), .rst_n(rst_n), .rsel(rsel), .rd_idx(iss_idx), .nb(nb),
    .u_old(u_old), .we(wr_v), .widx(wr_idx), .wdata(wr_data), .wb_first(wb_first)
  );

  memb_node_pipe #(.NODES(NODES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .iss_v(iss_v), .iss_idx(iss_idx), .nb(nb),
    .u_old(u_old), .stim(stim_data), .coef(coef),
    .wr_v(wr_v), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_valid <= 1'b0;
      edge_idx   <= '0;
      edge_data  <= '0;
      resp_valid <= 1'b0;
      resp_first <= '0;
      resp_last  <= '0;
    end else begin
      edge_valid <= wr_v && on_rim(int'(wr_idx), GRID);
      if (wr_v) begin
        edge_idx  <= wr_idx;
        edge_data <= wr_data;
      end
      resp_valid <= last_wr;
      if (last_wr) begin
        resp_first <= wb_first;
        resp_last  <= wr_data;
      end
    end
  end

endmodule

// File: rtl/membrane_step_engine_chk.sv
module membrane_step_engine_chk #(
  parameter int GRID = 8,
  localparam int NODES = GRID * GRID,
  localparam int IW = $clog2(NODES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          step_done,
  input logic          resp_valid,
  input logic          stim_rdy,
  input logic [IW-1:0] stim_idx,
  input logic          edge_valid,
  input logic [IW-1:0] edge_idx,
  input logic          wr_v,
  input logic [IW-1:0] wr_idx
);

  logic [IW:0] wcnt;
  int er, ec;
  assign er = int'(edge_idx) / GRID;
  assign ec = int'(edge_idx) % GRID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt <= '0;
    else if (step_done) wcnt <= wr_v ? (IW+1)'(1) : '0;
    else if (wr_v) wcnt <= wcnt + 1'b1;
  end

  a_r7_done_after_all_writes: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (wcnt == (IW+1)'(NODES)));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);

  a_r7_resp_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == step_done);

  a_r5_stim_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_rdy && $past(stim_rdy)) |-> (stim_idx == $past(stim_idx) + 1'b1));

  a_r5_write_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_v && $past(wr_v)) |-> (wr_idx == $past(wr_idx) + 1'b1));

  a_r8_edge_on_rim: assert property (@(posedge clk) disable iff (!rst_n)
    edge_valid |-> ((er == 0) || (er == GRID - 1) || (ec == 0) || (ec == GRID - 1)));

  a_r9_no_request_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stim_rdy);

endmodule

bind membrane_step_engine membrane_step_engine_chk #(.GRID(GRID)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .step_done(step_done),
  .resp_valid(resp_valid), .stim_rdy(stim_rdy), .stim_idx(stim_idx),
  .edge_valid(edge_valid), .edge_idx(edge_idx), .wr_v(wr_v), .wr_idx(wr_idx)
);

// File: tb/membrane_step_engine_bench.sv
`timescale 1ns/1ps
module membrane_step_engine_bench;

  localparam int G = 8;
  localparam int N = G * G;

  logic        clk = 1'b0, rst_n = 1'b0, step_go = 1'b0;
  logic        busy, step_done, stim_rdy, resp_valid, edge_valid;
  logic        coef_we = 1'b0;
  logic [1:0]  coef_sel = '0;
  logic [5:0]  coef_addr = '0, stim_idx, edge_idx;
  logic [31:0] coef_data = '0, stim_data = '0;
  logic [31:0] resp_first, resp_last, edge_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int cur[N], prv[N], nxt[N];
  int k_s1[N], k_p1[N], k_p2[N], k_p3[N];

  always #5 clk = ~clk;

  membrane_step_engine u_membrane_step_engine (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .busy(busy), .step_done(step_done),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_addr(coef_addr), .coef_data(coef_data),
    .stim_rdy(stim_rdy), .stim_idx(stim_idx), .stim_data(stim_data),
    .resp_valid(resp_valid), .resp_first(resp_first), .resp_last(resp_last),
    .edge_valid(edge_valid), .edge_idx(edge_idx), .edge_data(edge_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int qm(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return int'(p >>> 16);
  endfunction

  function automatic int stim_val(input int s, input int idx);
    if (s == 1) return (idx == 27) ? 32'h0001_0000 : 0;
    return (((idx * 131 + s * 71) % 97) - 48) * 1024;
  endfunction

  // expected next grid from the requirement formulas (R2, R3)
  task automatic model_step(input int s);
    for (int r = 0; r < G; r++)
      for (int c = 0; c < G; c++) begin
        int i, xi;
        i  = r * G + c;
        xi = (r > 0 ? cur[i-G] : 0) + (r < G-1 ? cur[i+G] : 0)
           + (c > 0 ? cur[i-1] : 0) + (c < G-1 ? cur[i+1] : 0) - 4 * cur[i];
        nxt[i] = qm(k_s1[i], xi) + qm(k_p1[i], cur[i]) + qm(k_p2[i], prv[i])
               + qm(k_p3[i], stim_val(s, i));
      end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      cur[i] = 0; prv[i] = 0; k_s1[i] = 0; k_p1[i] = 0; k_p2[i] = 0; k_p3[i] = 0;
    end
    chk(!busy && !step_done && !resp_valid && !stim_rdy && !edge_valid, "R1 reset outputs",
        {busy, step_done, resp_valid, stim_rdy, edge_valid}, 0);
  endtask

  task automatic wr_coef(input int idx, input int sel, input int val);
    coef_we = 1'b1; coef_addr = 6'(idx); coef_sel = 2'(sel); coef_data = val;
    @(negedge clk);
    coef_we = 1'b0;
    case (sel)
      0: k_s1[idx] = val;
      1: k_p1[idx] = val;
      2: k_p2[idx] = val;
      default: k_p3[idx] = val;
    endcase
  endtask

  task automatic t_load_all();
    for (int i = 0; i < N; i++) begin
      wr_coef(i, 0, (i % 5 == 0) ? 32'h0000_2000 : 32'h0000_4000);
      wr_coef(i, 1, 32'h0002_0000 - (i % 3) * 256);
      wr_coef(i, 2, 32'hFFFF_0000);
      wr_coef(i, 3, 32'h0001_0000 + i * 128);
    end
  endtask

  // one step; go_mid/coef_mid inject ignored traffic while busy (R9, R10)
  task automatic t_step(input int s, input string req, input bit go_mid, input bit coef_mid);
    int k, n_stim, n_edge, last_edge, done_k;
    bit ok_idx;
    model_step(s);
    n_stim = 0; n_edge = 0; last_edge = -1; done_k = -1; ok_idx = 1;
    step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    for (k = 0; k < 80 && done_k < 0; k++) begin
      if (edge_valid) begin
        chk(int'(edge_idx) > last_edge, "R8 edge order", edge_idx, last_edge + 1);
        chk(edge_data == nxt[edge_idx], {req, " R8 edge value"}, $signed(edge_data), nxt[edge_idx]);
        last_edge = int'(edge_idx);
        n_edge++;
      end
      if (step_done) begin
        done_k = k;
        chk(resp_valid, "R7 resp_valid with done", resp_valid, 1);
        chk(resp_first == nxt[0], {req, " R7 resp_first"}, $signed(resp_first), nxt[0]);
        chk(resp_last == nxt[N-1], {req, " R7 resp_last"}, $signed(resp_last), nxt[N-1]);
      end
      if (stim_rdy) begin
        if (int'(stim_idx) != k) ok_idx = 0;
        stim_data = stim_val(s, k);
        n_stim++;
      end else stim_data = '0;
      step_go = go_mid && (k == 10);
      if (coef_mid && k == 5) begin
        coef_we = 1'b1; coef_addr = 6'd63; coef_sel = 2'd0; coef_data = 32'h7FFF_0000;
      end else coef_we = 1'b0;
      if (done_k < 0) @(negedge clk);
    end
    step_go = 1'b0; coef_we = 1'b0;
    chk(done_k == 65, "R7 done timing", done_k, 65);
    chk(n_stim == N && ok_idx, "R5 stimulus requests", n_stim, N);
    chk(n_edge == 4 * G - 4, "R8 edge count", n_edge, 4 * G - 4);
    @(negedge clk);
    chk(!step_done && !busy, "R7 done single pulse", step_done, 0);
    for (int i = 0; i < N; i++) begin
      prv[i] = cur[i];
      cur[i] = nxt[i];
    end
  endtask

  task automatic t_quiet(input string req);
    bit any;
    any = 0;
    repeat (6) begin
      if (stim_rdy || busy || step_done) any = 1;
      @(negedge clk);
    end
    chk(!any, req, any, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R1/R4: zero coefficients give zero results
    t_step(0, "R1 zero coefs", 0, 0);
    t_load_all();
    // R2/R3: impulse then patterned stimulus
    t_step(1, "R2 impulse", 0, 0);
    t_step(2, "R3 pattern", 0, 0);
    // R6: recurrence across steps
    t_step(3, "R6 step3", 0, 0);
    t_step(4, "R6 step4", 0, 0);
    // R9: go during busy is dropped
    t_step(5, "R9 go mid", 1, 0);
    t_quiet("R9 no extra step");
    // R10: coefficient write during busy is dropped (model keeps old value)
    t_step(6, "R10 coef mid", 0, 1);
    t_step(7, "R10 after", 0, 0);
    // R4: per-node coefficient change on the response nodes
    wr_coef(0, 3, 32'h0003_0000);
    wr_coef(63, 0, 32'h0000_8000);
    wr_coef(63, 2, 32'hFFFF_8000);
    t_step(8, "R4 new coefs", 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule